// File: doc/BRIEF.md
# Serial-Frame Register File Writer for a Test Access Port User Channel

This block is a serial data register that hangs off a user channel of a boundary-scan test access port. The external TAP controller drives a select line, a shift-enable, an update strobe, the data-register clock and the serial input. While the channel is selected and shift is asserted, each data-register clock moves one bit of a six-bit frame into the chain. The frame carries a 2-bit address and a 4-bit data word. The bit falling off the far end of the chain goes back to the controller on the serial output. A host therefore reads back the frame it loaded last time while it loads the next one.

When the controller raises the update strobe and the channel is selected, the block gives one write pulse. It presents the address and data held in the chain, and a small four-entry register file stores the data word at that address. The register file is part of this project so that the writes can be observed. The host can go back to shifting and updating as often as it likes, with no new instruction. Each update writes one more entry.

Top module: `jtag_uport_regfile`

## Requirements
- R1: While `tap_rst_n` is low, the chain, the register file and the write outputs are all zero. `tdo` reads 0, `wr_en` is 0 and `rf_dump` is all zeros.
- R2: The chain moves only on a `dr_clk` rising edge where `shift_en` and `port_sel` are both high. When `port_sel` is low, shift pulses leave `tdo` and the stored frame unchanged.
- R3: A bit presented on `tdi` during a shifting cycle appears on `tdo` after exactly 6 shifting edges.
- R4: While a new frame is being shifted in, `tdo` gives the previously loaded frame one bit per shift, starting with that frame's bit 0.
- R5: The frame is shifted in this order: data bit 0, data bits 1 to 3, then address bit 0 and address bit 1. This puts the data field nearest `tdo`. On update, `wr_addr` and `wr_data` carry those fields and the addressed entry of `rf_dump` takes the data. Entry i is `rf_dump[4*i+3:4*i]`.
- R6: An update strobe seen while `port_sel` is low produces no `wr_en` pulse, and the register file is left unchanged.
- R7: Each selected update gives exactly one `wr_en` pulse, one `dr_clk` cycle wide, even when `update_en` stays high for several cycles.
- R8: Shifting a new frame and updating again performs a further write, and frames can be repeated any number of times without other action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dr_clk | input | 1 | Data-register clock from the TAP controller |
| tap_rst_n | input | 1 | Asynchronous active-low TAP reset |
| port_sel | input | 1 | High while this user channel's instruction is loaded |
| shift_en | input | 1 | High in the shift state of the data-register path |
| update_en | input | 1 | High in the update state of the data-register path |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain end nearest the data LSB) |
| wr_addr | output | 2 | Write address presented with the write pulse |
| wr_data | output | 4 | Write data presented with the write pulse |
| wr_en | output | 1 | One-cycle register file write pulse |
| rf_dump | output | 16 | Flat view of all four register file entries |

## Verification
The bench holds `update_en` high for three cycles. A design that only gated the strobe would then write on every one of those cycles instead of once. It shifts a frame and gives an update with the channel deselected. A block that ignored the select would either move the stale frame along or write it, and either would show up as a wrong `tdo` bit or a register change. Every selected shift compares `tdo` with the frame loaded before. A reversed bit order or a swapped address/data split would therefore show on the serial output, and would also place the data in the wrong register entry.

// File: rtl/jur_pkg.sv
package jur_pkg;
  localparam int unsigned JUR_ADDR_W = 2;
  localparam int unsigned JUR_DATA_W = 4;
  localparam int unsigned JUR_SYNC_STAGES = 2;

  typedef enum logic [0:0] {
    UPD_IDLE = 1'b0,
    UPD_HELD = 1'b1
  } upd_state_e;
endpackage

// File: rtl/jur_rst_sync.sv
module jur_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_n;

  always_comb begin
    stage_n = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= stage_n;
  end

  assign srst_n = stage_q[STAGES-1];
endmodule

// File: rtl/jur_shift_chain.sv
module jur_shift_chain #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             ser_in,
  output logic [WIDTH-1:0] frame_q,
  output logic             ser_out
);
  logic [WIDTH-1:0] frame_n;

  // New bits enter at the top, the bit at index 0 leaves first.
  always_comb begin
    frame_n = frame_q;
    if (adv) frame_n = {ser_in, frame_q[WIDTH-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= '0;
    else        frame_q <= frame_n;
  end

  assign ser_out = frame_q[0];
endmodule

// File: rtl/jur_update_ctl.sv
module jur_update_ctl
  import jur_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel,
  input  logic                     update,
  input  logic [ADDR_W+DATA_W-1:0] frame,
  output logic                     wr_en,
  output logic [ADDR_W-1:0]        wr_addr,
  output logic [DATA_W-1:0]        wr_data
);
  localparam int unsigned FRAME_W = ADDR_W + DATA_W;

  upd_state_e          state_q, state_n;
  logic                wr_en_n;
  logic [ADDR_W-1:0]   addr_n;
  logic [DATA_W-1:0]   data_n;
  logic                strobe;

  assign strobe = update & sel;

  always_comb begin
    state_n = state_q;
    wr_en_n = 1'b0;
    addr_n  = wr_addr;
    data_n  = wr_data;
    unique case (state_q)
      UPD_IDLE: begin
        if (strobe) begin
          wr_en_n = 1'b1;
          addr_n  = frame[FRAME_W-1:DATA_W];
          data_n  = frame[DATA_W-1:0];
          state_n = UPD_HELD;
        end
      end
      UPD_HELD: begin
        if (!strobe) state_n = UPD_IDLE;
      end
      default: state_n = UPD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= UPD_IDLE;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      state_q <= state_n;
      wr_en   <= wr_en_n;
      wr_addr <= addr_n;
      wr_data <= data_n;
    end
  end
endmodule

// File: rtl/jur_regfile.sv
module jur_regfile #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [ADDR_W-1:0]                waddr,
  input  logic [DATA_W-1:0]                wdata,
  output logic [(1<<ADDR_W)*DATA_W-1:0]    dump
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    logic              ent_we;
    logic [DATA_W-1:0] ent_q;
    logic [DATA_W-1:0] ent_n;

    always_comb begin
      ent_we = we && (waddr == ADDR_W'(gi));
      ent_n  = ent_we ? wdata : ent_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q <= '0;
      else        ent_q <= ent_n;
    end

    assign dump[gi*DATA_W +: DATA_W] = ent_q;
  end
endmodule

// File: rtl/jtag_uport_regfile.sv
module jtag_uport_regfile
  import jur_pkg::*;
#(
  parameter int unsigned ADDR_W = JUR_ADDR_W,
  parameter int unsigned DATA_W = JUR_DATA_W
) (
  input  logic                          dr_clk,
  input  logic                          tap_rst_n,
  input  logic                          port_sel,
  input  logic                          shift_en,
  input  logic                          update_en,
  input  logic                          tdi,
  output logic                          tdo,
  output logic [ADDR_W-1:0]             wr_addr,
  output logic [DATA_W-1:0]             wr_data,
  output logic                          wr_en,
  output logic [(1<<ADDR_W)*DATA_W-1:0] rf_dump
);
  localparam int unsigned FRAME_W = ADDR_W + DATA_W;

  logic               rst_n;
  logic               chain_adv;
  logic [FRAME_W-1:0] chain_q;

  jur_rst_sync #(.STAGES(JUR_SYNC_STAGES)) u_rst (
    .clk    (dr_clk),
    .arst_n (tap_rst_n),
    .srst_n (rst_n)
  );

  assign chain_adv = shift_en & port_sel;

  jur_shift_chain #(.WIDTH(FRAME_W)) u_chain (
    .clk     (dr_clk),
    .rst_n   (rst_n),
    .adv     (chain_adv),
    .ser_in  (tdi),
    .frame_q (chain_q),
    .ser_out (tdo)
  );

  jur_update_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_upd (
    .clk     (dr_clk),
    .rst_n   (rst_n),
    .sel     (port_sel),
    .update  (update_en),
    .frame   (chain_q),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  jur_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rf (
    .clk   (dr_clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .dump  (rf_dump)
  );
endmodule

// File: rtl/jur_uport_regfile_chk.sv
module jur_uport_regfile_chk #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 4
) (
  input logic                          dr_clk,
  input logic                          tap_rst_n,
  input logic                          port_sel,
  input logic                          shift_en,
  input logic                          update_en,
  input logic                          tdo,
  input logic [ADDR_W-1:0]             wr_addr,
  input logic [DATA_W-1:0]             wr_data,
  input logic                          wr_en,
  input logic [(1<<ADDR_W)*DATA_W-1:0] rf_dump
);
  always @(posedge dr_clk) begin
    if (!tap_rst_n) begin
      a_r1_reset_quiet: assert (!wr_en && !tdo && rf_dump == '0)
        else $error("R1: outputs not cleared in reset");
    end
  end

  a_r2_hold_unselected: assert property (@(posedge dr_clk) disable iff (!tap_rst_n)
    !(shift_en && port_sel) |=> $stable(tdo));

  a_r5_write_lands: assert property (@(posedge dr_clk) disable iff (!tap_rst_n)
    wr_en |=> rf_dump[$past(wr_addr)*DATA_W +: DATA_W] == $past(wr_data));

  a_r6_needs_select: assert property (@(posedge dr_clk) disable iff (!tap_rst_n)
    wr_en |-> $past(port_sel && update_en));

  a_r7_single_pulse: assert property (@(posedge dr_clk) disable iff (!tap_rst_n)
    wr_en |=> !wr_en);
endmodule

bind jtag_uport_regfile jur_uport_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .dr_clk    (dr_clk),
  .tap_rst_n (tap_rst_n),
  .port_sel  (port_sel),
  .shift_en  (shift_en),
  .update_en (update_en),
  .tdo       (tdo),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .wr_en     (wr_en),
  .rf_dump   (rf_dump)
);

// File: tb/jtag_uport_regfile_bench.sv
module jtag_uport_regfile_bench;
  localparam int CLK_P = 10;

  logic        dr_clk = 1'b0;
  logic        tap_rst_n = 1'b0;
  logic        port_sel = 1'b0;
  logic        shift_en = 1'b0;
  logic        update_en = 1'b0;
  logic        tdi = 1'b0;
  logic        tdo;
  logic [1:0]  wr_addr;
  logic [3:0]  wr_data;
  logic        wr_en;
  logic [15:0] rf_dump;

  always #(CLK_P/2) dr_clk = ~dr_clk;

  jtag_uport_regfile u_jtag_uport_regfile (
    .dr_clk    (dr_clk),
    .tap_rst_n (tap_rst_n),
    .port_sel  (port_sel),
    .shift_en  (shift_en),
    .update_en (update_en),
    .tdi       (tdi),
    .tdo       (tdo),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_en     (wr_en),
    .rf_dump   (rf_dump)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [5:0] exp_q[$];
  logic [5:0] prev_frame = '0;
  logic [3:0] exp_rf [4];
  bit prev_we = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every write pulse.
  always @(negedge dr_clk) begin
    if (tap_rst_n) begin
      if (wr_en) begin
        chk(!prev_we, "R7", "write pulse longer than one cycle", 1, 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", "unexpected write", {wr_addr, wr_data}, 0);
        end else begin
          logic [5:0] e;
          e = exp_q.pop_front();
          chk(wr_addr == e[5:4], "R5", "write address", wr_addr, e[5:4]);
          chk(wr_data == e[3:0], "R5", "write data", wr_data, e[3:0]);
        end
      end
      prev_we = wr_en;
    end
  end

  task automatic shift_frame(input logic [1:0] a, input logic [3:0] d, input bit sel);
    logic [5:0] f;
    f = {a, d};
    for (int i = 0; i < 6; i++) begin
      @(negedge dr_clk);
      if (sel) chk(tdo == prev_frame[i], "R4", "old frame bit on tdo", tdo, prev_frame[i]);
      port_sel = sel;
      shift_en = 1'b1;
      tdi = f[i];
    end
    @(negedge dr_clk);
    shift_en = 1'b0;
    tdi = 1'b0;
    port_sel = 1'b1;
    if (sel) begin
      chk(tdo == f[0], "R3", "first bit after 6 shifts", tdo, f[0]);
      prev_frame = f;
    end else begin
      chk(tdo == prev_frame[0], "R2", "tdo moved while deselected", tdo, prev_frame[0]);
    end
  endtask

  task automatic do_update(input int cyc, input bit sel);
    @(negedge dr_clk);
    port_sel = sel;
    update_en = 1'b1;
    if (sel) exp_q.push_back(prev_frame);
    repeat (cyc - 1) @(negedge dr_clk);
    @(negedge dr_clk);
    update_en = 1'b0;
    port_sel = 1'b1;
    if (sel) exp_rf[prev_frame[5:4]] = prev_frame[3:0];
    repeat (3) @(negedge dr_clk);
  endtask

  task automatic check_rf(input string req);
    for (int i = 0; i < 4; i++)
      chk(rf_dump[i*4 +: 4] == exp_rf[i], req, $sformatf("entry %0d", i),
          rf_dump[i*4 +: 4], exp_rf[i]);
  endtask

  initial begin
    #(CLK_P * 50000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) exp_rf[i] = '0;
    repeat (3) @(negedge dr_clk);
    // R1: reset state
    chk(tdo == 1'b0, "R1", "tdo in reset", tdo, 0);
    chk(wr_en == 1'b0, "R1", "wr_en in reset", wr_en, 0);
    chk(rf_dump == '0, "R1", "register file in reset", rf_dump, 0);
    tap_rst_n = 1'b1;
    port_sel = 1'b1;
    repeat (4) @(negedge dr_clk);

    // R5: basic frame and write
    shift_frame(2'd1, 4'hA, 1'b1);
    do_update(1, 1'b1);
    check_rf("R5");

    // R7: long update strobe writes once
    shift_frame(2'd3, 4'h5, 1'b1);
    do_update(3, 1'b1);
    check_rf("R7");

    // R8: back-to-back frames, no other action
    shift_frame(2'd0, 4'hF, 1'b1);
    do_update(1, 1'b1);
    shift_frame(2'd2, 4'hC, 1'b1);
    do_update(1, 1'b1);
    check_rf("R8");

    // R2: deselected shifting leaves chain intact; next frame reads out {2,C}
    shift_frame(2'd1, 4'h0, 1'b0);
    shift_frame(2'd1, 4'h3, 1'b1);

    // R6: deselected update must not write
    do_update(2, 1'b0);
    check_rf("R6");
    chk(exp_q.size() == 0, "R6", "pending writes", exp_q.size(), 0);

    // R8: later selected update still writes the same frame
    do_update(1, 1'b1);
    check_rf("R8");

    chk(exp_q.size() == 0, "R7", "missing writes", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule